// File: doc/BRIEF.md
# Vector Three-Register Logic and Lane Add/Subtract Unit

This execution unit sits beside a 128-bit vector register file. Each cycle it may accept one 32-bit instruction word together with the present contents of the destination register and the two source registers. It decodes the register indices and control fields and returns the new destination value, tagged with the destination index, a write enable and an illegal flag.

It serves two operation groups. The bitwise group offers eight operations, chosen by a 3-bit selector formed as size + 4*U. Three of them are select/insert forms that also take the old destination value as an operand. The arithmetic group adds or subtracts per lane, at a lane width picked by the size field. Carries stay inside each lane. The Q bit chooses between the full 128-bit vector and the low 64 bits. In the 64-bit case the upper half of the destination is written as zero. The result is captured in a single output register, so it appears one clock after the instruction is presented.

Top module: `vlu_unit`

## Requirements
- R1: An instruction is accepted only when bit 31 is 0, bits [28:24] are 01110, bit 21 is 1, bit 10 is 1 and opcode bits [15:11] are 00011 (bitwise group) or 10000 (arithmetic group). Any other word gives out_illegal=1, out_wen=0 and out_data=0.
- R2: In the bitwise group, with sel = size + 4*U (size = bits [23:22], U = bit 29), sel 0 gives n AND m, sel 1 gives n AND NOT m, sel 2 gives n OR m and sel 3 gives n OR NOT m. Here n is source index bits [9:5] and m is source index bits [20:16].
- R3: Bitwise sel 4 gives n XOR m.
- R4: Bitwise sel 5 (select) gives, for each bit, n where old d is 1 and m where old d is 0.
- R5: Bitwise sel 6 (insert-true) gives, for each bit, n where m is 1 and old d where m is 0.
- R6: Bitwise sel 7 (insert-false) gives, for each bit, n where m is 0 and old d where m is 1.
- R7: With Q (bit 30) equal to 0, the low 64 bits carry the result and out_data[127:64] is zero. With Q=1 all 128 bits carry the result.
- R8: In the arithmetic group, U=0 adds per lane. Lane width is 8, 16, 32 or 64 bits for size 0, 1, 2 or 3. Each lane wraps modulo 2^width and no carry crosses a lane.
- R9: In the arithmetic group, U=1 subtracts m from n per lane, with the same lane widths and the same wrap.
- R10: An arithmetic instruction with size 3 and Q=0 is illegal: out_illegal=1, out_wen=0.
- R11: Results appear exactly one clock after in_valid. out_valid follows in_valid, out_rd carries bits [4:0], and out_wen = out_valid AND NOT out_illegal. A cycle without in_valid gives all outputs zero.
- R12: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| insn | input | 32 | Instruction word |
| vd_old | input | 128 | Current destination register value |
| vn | input | 128 | First source register value |
| vm | input | 128 | Second source register value |
| out_valid | output | 1 | Result register holds a retired instruction |
| out_wen | output | 1 | Write the result to the register file |
| out_illegal | output | 1 | Instruction word not supported |
| out_rd | output | 5 | Destination index |
| out_data | output | 128 | New destination value |

## Verification
Every result is due at the first rising edge after the instruction is presented, with no variation by operation, lane width or legality. The bench drives each instruction at a falling edge. At the next falling edge it compares all outputs against the value its behavioural model worked out for that instruction. Because a comparison is made on every clock, idle cycles and back-to-back instructions are checked at the same fixed offset.

// File: rtl/vlu_pkg.sv
package vlu_pkg;

    localparam int VEC_W    = 128;
    localparam int HALF_W   = VEC_W / 2;
    localparam int RIDX_W   = 5;
    localparam int NUM_LW   = 4;
    localparam int BASE_LW  = 8;

    localparam logic [4:0] OPC_BITWISE = 5'b00011;
    localparam logic [4:0] OPC_ARITH   = 5'b10000;
    localparam logic [4:0] GROUP_PAT   = 5'b01110;

    typedef enum logic [2:0] {
        BW_AND  = 3'd0,
        BW_ANDN = 3'd1,
        BW_OR   = 3'd2,
        BW_ORN  = 3'd3,
        BW_XOR  = 3'd4,
        BW_SEL  = 3'd5,
        BW_INST = 3'd6,
        BW_INSF = 3'd7
    } bw_op_e;

    typedef struct packed {
        logic [RIDX_W-1:0] rd;
        logic              is_bw;
        logic              is_arith;
        logic              illegal;
        bw_op_e            bw_op;
        logic [1:0]        lane_sz;
        logic              sub;
        logic              full;
    } dec_t;

    typedef struct packed {
        logic              valid;
        logic              wen;
        logic              illegal;
        logic [RIDX_W-1:0] rd;
        logic [VEC_W-1:0]  data;
    } res_t;

endpackage

// File: rtl/vlu_decode.sv
module vlu_decode
    import vlu_pkg::*;
(
    input  logic [31:0] insn,
    output dec_t        dec
);
    logic       frame_ok;
    logic [4:0] opc;
    logic       u_bit;
    logic [1:0] sz;

    always_comb begin
        opc      = insn[15:11];
        u_bit    = insn[29];
        sz       = insn[23:22];
        frame_ok = !insn[31] && (insn[28:24] == GROUP_PAT) && insn[21] && insn[10];

        dec          = '0;
        dec.rd       = insn[4:0];
        dec.full     = insn[30];
        dec.lane_sz  = sz;
        dec.sub      = u_bit;
        dec.bw_op    = bw_op_e'({u_bit, sz});
        dec.is_bw    = frame_ok && (opc == OPC_BITWISE);
        dec.is_arith = frame_ok && (opc == OPC_ARITH) && !(sz == 2'd3 && !insn[30]);
        dec.illegal  = !(dec.is_bw || dec.is_arith);
    end
endmodule

// File: rtl/vlu_bitwise.sv
module vlu_bitwise
    import vlu_pkg::*;
(
    input  bw_op_e           op,
    input  logic [VEC_W-1:0] d_old,
    input  logic [VEC_W-1:0] n,
    input  logic [VEC_W-1:0] m,
    output logic [VEC_W-1:0] res
);
    logic [VEC_W-1:0] diff_nm;
    logic [VEC_W-1:0] diff_nd;

    always_comb begin
        diff_nm = n ^ m;
        diff_nd = n ^ d_old;
        unique case (op)
            BW_AND:  res = n & m;
            BW_ANDN: res = n & ~m;
            BW_OR:   res = n | m;
            BW_ORN:  res = n | ~m;
            BW_XOR:  res = diff_nm;
            BW_SEL:  res = m ^ (diff_nm & d_old);
            BW_INST: res = d_old ^ (diff_nd & m);
            BW_INSF: res = d_old ^ (diff_nd & ~m);
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/vlu_lanes.sv
module vlu_lanes
    import vlu_pkg::*;
(
    input  logic [1:0]       lane_sz,
    input  logic             sub,
    input  logic [VEC_W-1:0] n,
    input  logic [VEC_W-1:0] m,
    output logic [VEC_W-1:0] res
);
    logic [VEC_W-1:0] cand [NUM_LW];

    for (genvar gw = 0; gw < NUM_LW; gw++) begin : g_width
        localparam int LW = BASE_LW << gw;
        localparam int NL = VEC_W / LW;
        for (genvar gl = 0; gl < NL; gl++) begin : g_lane
            logic [LW-1:0] a_l;
            logic [LW-1:0] b_l;
            assign a_l = n[gl*LW +: LW];
            assign b_l = m[gl*LW +: LW];
            assign cand[gw][gl*LW +: LW] = sub ? (a_l - b_l) : (a_l + b_l);
        end
    end

    always_comb begin
        res = cand[lane_sz];
    end
endmodule

// File: rtl/vlu_unit.sv
module vlu_unit
    import vlu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [31:0]        insn,
    input  logic [127:0]       vd_old,
    input  logic [127:0]       vn,
    input  logic [127:0]       vm,
    output logic               out_valid,
    output logic               out_wen,
    output logic               out_illegal,
    output logic [4:0]         out_rd,
    output logic [127:0]       out_data
);
    dec_t             dec;
    logic [VEC_W-1:0] bw_res;
    logic [VEC_W-1:0] ar_res;
    logic [VEC_W-1:0] sel_res;
    res_t             res_d;
    res_t             res_q;

    vlu_decode u_dec (
        .insn (insn),
        .dec  (dec)
    );

    vlu_bitwise u_bw (
        .op    (dec.bw_op),
        .d_old (vd_old),
        .n     (vn),
        .m     (vm),
        .res   (bw_res)
    );

    vlu_lanes u_ar (
        .lane_sz (dec.lane_sz),
        .sub     (dec.sub),
        .n       (vn),
        .m       (vm),
        .res     (ar_res)
    );

    always_comb begin
        sel_res = dec.is_arith ? ar_res : (dec.is_bw ? bw_res : '0);
        if (!dec.full) begin
            sel_res[VEC_W-1:HALF_W] = '0;
        end
        res_d = '0;
        if (in_valid) begin
            res_d.valid   = 1'b1;
            res_d.illegal = dec.illegal;
            res_d.wen     = !dec.illegal;
            res_d.rd      = dec.rd;
            res_d.data    = sel_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid   = res_q.valid;
    assign out_wen     = res_q.wen;
    assign out_illegal = res_q.illegal;
    assign out_rd      = res_q.rd;
    assign out_data    = res_q.data;

    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && out_rd == $past(insn[4:0])));
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_wen));
    p_illegal_nowen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> !out_wen);
    p_half_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !insn[30]) |=> (out_data[127:64] == '0));
    p_bad_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !insn[10]) |=> (out_illegal && out_data == '0));
endmodule

// File: tb/vlu_unit_test.sv
module vlu_unit_test;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  insn = '0;
    logic [127:0] vd_old = '0;
    logic [127:0] vn = '0;
    logic [127:0] vm = '0;
    logic         out_valid;
    logic         out_wen;
    logic         out_illegal;
    logic [4:0]   out_rd;
    logic [127:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vlu_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .vd_old(vd_old), .vn(vn), .vm(vm),
        .out_valid(out_valid), .out_wen(out_wen), .out_illegal(out_illegal),
        .out_rd(out_rd), .out_data(out_data)
    );

    function automatic logic [31:0] mk(input logic u, input logic q, input logic [1:0] sz,
                                       input logic [4:0] opc, input logic [4:0] rd,
                                       input logic [4:0] rn, input logic [4:0] rm);
        return {1'b0, q, u, 5'b01110, sz, 1'b1, rm, opc, 1'b1, rn, rd};
    endfunction

    function automatic logic [127:0] model_data(input logic [31:0] w, input logic [127:0] d,
                                                input logic [127:0] a, input logic [127:0] b,
                                                output logic ill);
        logic [127:0] r;
        int sel;
        int lw;
        logic [63:0] mask;
        logic [63:0] x;
        logic [63:0] y;
        r = '0;
        ill = 1'b1;
        sel = int'(w[23:22]) + 4 * int'(w[29]);
        if (w[31] == 1'b0 && w[28:24] == 5'b01110 && w[21] && w[10]) begin
            if (w[15:11] == 5'b00011) begin
                ill = 1'b0;
                for (int i = 0; i < 128; i++) begin
                    case (sel)
                        0: r[i] = a[i] & b[i];
                        1: r[i] = a[i] & !b[i];
                        2: r[i] = a[i] | b[i];
                        3: r[i] = a[i] | !b[i];
                        4: r[i] = a[i] ^ b[i];
                        5: r[i] = d[i] ? a[i] : b[i];
                        6: r[i] = b[i] ? a[i] : d[i];
                        default: r[i] = b[i] ? d[i] : a[i];
                    endcase
                end
            end else if (w[15:11] == 5'b10000 && !(w[23:22] == 2'd3 && !w[30])) begin
                ill = 1'b0;
                lw = 8 << w[23:22];
                mask = (lw == 64) ? {64{1'b1}} : ((64'd1 << lw) - 64'd1);
                for (int l = 0; l < 128 / lw; l++) begin
                    x = 64'(a >> (l * lw)) & mask;
                    y = 64'(b >> (l * lw)) & mask;
                    x = (w[29] ? (x - y) : (x + y)) & mask;
                    r = r | (128'(x) << (l * lw));
                end
            end
        end
        if (!w[30]) r[127:64] = '0;
        return r;
    endfunction

    task automatic step(input logic v, input logic [31:0] w, input logic [127:0] d,
                        input logic [127:0] a, input logic [127:0] b, input string req);
        logic         e_ill;
        logic [127:0] e_data;
        logic         e_wen;
        logic [4:0]   e_rd;
        in_valid = v; insn = w; vd_old = d; vn = a; vm = b;
        e_data = model_data(w, d, a, b, e_ill);
        if (!v) begin e_data = '0; e_ill = 1'b0; end
        e_wen = v && !e_ill;
        e_rd  = v ? w[4:0] : 5'd0;
        @(negedge clk);
        checks++;
        if (out_valid !== v || out_wen !== e_wen || out_illegal !== e_ill ||
            out_rd !== e_rd || out_data !== e_data) begin
            errors++;
            $display("FAIL %s: got v=%b w=%b i=%b rd=%0d data=%h exp v=%b w=%b i=%b rd=%0d data=%h",
                     req, out_valid, out_wen, out_illegal, out_rd, out_data,
                     v, e_wen, e_ill, e_rd, e_data);
        end
    endtask

    localparam logic [4:0] OB = 5'b00011;
    localparam logic [4:0] OA = 5'b10000;

    initial begin
        logic [127:0] pa;
        logic [127:0] pb;
        logic [127:0] pd;
        pa = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        pb = 128'hF0F0_0FF0_AAAA_5555_3C3C_C3C3_FFFF_0000;
        pd = 128'hFFFF_0000_1234_8765_0F0F_F0F0_A5A5_5A5A;

        repeat (2) @(negedge clk);
        checks++;
        if ({out_valid, out_wen, out_illegal, out_rd} !== 8'd0 || out_data !== '0) begin
            errors++;
            $display("FAIL R12: got v=%b rd=%0d data=%h exp all zero", out_valid, out_rd, out_data);
        end
        rst_n = 1'b1;
        @(negedge clk);

        step(1, mk(0,1,2'd0,OB,5'd1,5'd2,5'd3), pd, pa, pb, "R2 and");
        step(1, mk(0,1,2'd1,OB,5'd4,5'd2,5'd3), pd, pa, pb, "R2 andn");
        step(1, mk(0,1,2'd2,OB,5'd5,5'd2,5'd3), pd, pa, pb, "R2 or");
        step(1, mk(0,1,2'd3,OB,5'd6,5'd2,5'd3), pd, pa, pb, "R2 orn");
        step(1, mk(1,1,2'd0,OB,5'd7,5'd2,5'd3), pd, pa, pb, "R3 xor");
        step(1, mk(1,1,2'd1,OB,5'd8,5'd2,5'd3), pd, pa, pb, "R4 select");
        step(1, mk(1,1,2'd2,OB,5'd9,5'd2,5'd3), pd, pa, pb, "R5 insert-true");
        step(1, mk(1,1,2'd3,OB,5'd10,5'd2,5'd3), pd, pa, pb, "R6 insert-false");
        step(1, mk(1,0,2'd1,OB,5'd11,5'd2,5'd3), pd, pa, pb, "R7 half select");
        step(1, mk(0,0,2'd2,OB,5'd12,5'd2,5'd3), pd, pa, pb, "R7 half or");
        step(0, mk(0,1,2'd0,OB,5'd13,5'd2,5'd3), pd, pa, pb, "R11 idle");
        for (int s = 0; s < 4; s++) begin
            step(1, mk(0,1,2'(s),OA,5'(14+s),5'd1,5'd2), pd, {128{1'b1}},
                 128'h0001_0001_0001_0001_0001_0001_0001_0001, "R8 add carry");
            step(1, mk(0,1,2'(s),OA,5'(18+s),5'd1,5'd2), pd, pa, pb, "R8 add mixed");
        end
        for (int s = 0; s < 3; s++) begin
            step(1, mk(1,0,2'(s),OA,5'(22+s),5'd1,5'd2), pd, '0,
                 128'h0000_0000_0000_0001_0000_0001_0000_0001, "R9 sub borrow half");
        end
        step(1, mk(1,1,2'd3,OA,5'd25,5'd1,5'd2), pd, pb, pa, "R9 sub 64");
        step(1, mk(1,1,2'd0,OA,5'd26,5'd1,5'd2), pd, pa, pb, "R9 sub 8");
        step(1, mk(0,0,2'd3,OA,5'd27,5'd1,5'd2), pd, pa, pb, "R10 illegal 64 half");
        step(1, mk(1,0,2'd3,OA,5'd28,5'd1,5'd2), pd, pa, pb, "R10 illegal 64 half sub");
        step(1, mk(0,1,2'd0,5'b00111,5'd29,5'd1,5'd2), pd, pa, pb, "R1 other opcode");
        step(1, mk(0,1,2'd0,OB,5'd30,5'd1,5'd2) & ~32'h0000_0400, pd, pa, pb, "R1 bit10 clear");
        step(1, mk(0,1,2'd0,OB,5'd31,5'd1,5'd2) | 32'h8000_0000, pd, pa, pb, "R1 bit31 set");
        step(1, mk(0,1,2'd0,OA,5'd3,5'd1,5'd2) & ~32'h0020_0000, pd, pa, pb, "R1 bit21 clear");
        step(1, mk(1,1,2'd1,OB,5'd2,5'd4,5'd5), pa, pb, pd, "R4 back-to-back");
        step(1, mk(0,1,2'd1,OA,5'd0,5'd4,5'd5), pa, pb, pd, "R11 back-to-back add");
        step(0, '0, '0, '0, '0, "R11 idle end");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got no completion exp completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule